// File: doc/BRIEF.md
# Master Clock Source Switch Controller

This block decides which oscillator drives the system master clock and runs the handover from one oscillator to another. Software reaches it through a small register bus. It writes a one-byte source code into a target register. The controller then turns on the enable of the requested oscillator and waits for that oscillator's ready input. It changes the master selection only when the protocol allows it. The glitch-free clock multiplexer, the oscillators and the prescaler sit outside this block. Each oscillator appears here only as an enable output and a ready input.

The block has two modes. In the automatic mode, software sets the go bit before it writes the target. The switch then completes on the first cycle in which the target reports ready. In the manual mode, the go bit is clear at the time of the write. When the target becomes ready, the done flag rises but the old source stays selected. The switch happens only when software later sets go. A pending switch can be cancelled by writing the busy bit to zero. This rolls the target register back to the source that is currently the master. After reset the master is the fast internal oscillator, running through its divide-by-8 prescaler setting, which lies outside this block. A configuration input can forbid the slow internal oscillator from becoming master.

Top module: `clk_source_switch`

## Requirements
- R1: After reset, the status register (address 1) and the target register (address 0) both read 0xE1. The control register (address 2) reads 0x00. `osc_enable` is 3'b001, `master_sel` is 3'b001 and `switch_irq` is low.
- R2: Only three source codes are legal: 0xE1 for the fast internal oscillator (index 0), 0xD2 for the slow internal oscillator (index 1) and 0xB4 for the external oscillator (index 2). A target write of any other code is ignored: the target register keeps its value and busy stays clear.
- R3: A legal target write while the block is idle has three effects. It loads the target register. It sets busy, which is control bit 0. It sets the `osc_enable` bit of the requested source.
- R4: While busy is set, `master_sel` and the status register keep their values, and writes to the target register are ignored.
- R5: Go is control bit 1. If go is set when the target's ready input is seen, then on that clock edge the status register takes the target code, busy clears, `master_sel` becomes the one-hot index of the target, and the done flag sets. The done flag is control bit 3.
- R6: If go is clear when the target's ready input is seen, the done flag sets and busy stays set. A later control write with go=1 and busy=1 completes the switch on the following clock edge.
- R7: `switch_irq` is high exactly while the done flag and the interrupt enable are both set. The interrupt enable is control bit 2.
- R8: Only a control write with bit 3 equal to 0 clears the done flag. Writing 1 to bit 3 leaves the flag unchanged.
- R9: The hardware never clears a bit of `osc_enable`. Only writes to the enable register (address 3, bit i for source i) do, so the previous master's oscillator stays enabled after a switch.
- R10: A control write with bit 0 equal to 0 while busy is set aborts the switch. Busy clears, the target register returns to the status register value, and the master selection does not change.
- R11: While `slow_master_lock` is high, a target write of 0xD2 is ignored, just like an illegal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 target, 1 status, 2 control, 3 oscillator enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| osc_ready | input | 3 | Per-source ready (stable) indications |
| slow_master_lock | input | 1 | Forbids the slow internal oscillator as master |
| osc_enable | output | 3 | Per-source oscillator enables |
| master_sel | output | 3 | One-hot master clock source select |
| switch_irq | output | 1 | Switch-done interrupt |

## Verification
The checker watches every cycle for the following:
- `master_sel` is always one-hot.
- The selection never moves while a switch is in flight.
- The status register changes only on the edge where busy falls.
- The done flag rises only during a switch.
- No oscillator enable drops unless an enable-register write caused it.
- A switch that begins while the lock is high never targets the slow source.

Some behaviour shows only in the bench's sequences:
- Automatic and manual completion, each with its exact register contents.
- Abort rolling the target back.
- Write-1 immunity of the done flag.
- Rejection of illegal or locked codes.
- Interrupt gating with the enable bit both set and clear.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int N_SRC = 3;
    localparam int REG_W = 8;
    localparam int ADR_W = 2;

    // source indices (bit position in enable/ready/select vectors)
    localparam int SRC_FAST = 0;
    localparam int SRC_SLOW = 1;
    localparam int SRC_EXT  = 2;

    localparam logic [REG_W-1:0] CODE_FAST = 8'hE1;
    localparam logic [REG_W-1:0] CODE_SLOW = 8'hD2;
    localparam logic [REG_W-1:0] CODE_EXT  = 8'hB4;

    typedef enum logic [ADR_W-1:0] {
        RA_TARGET = 2'd0,
        RA_STATUS = 2'd1,
        RA_CTRL   = 2'd2,
        RA_OSCEN  = 2'd3
    } reg_addr_e;

    // control register bit positions
    localparam int CB_BUSY = 0;
    localparam int CB_GO   = 1;
    localparam int CB_IE   = 2;
    localparam int CB_DONE = 3;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_WAIT = 2'd1,
        SW_HOLD = 2'd2
    } sw_state_e;

    typedef struct packed {
        logic done;
        logic ie;
        logic go;
    } ctrl_t;

    function automatic logic [REG_W-1:0] src_code(input int idx);
        case (idx)
            SRC_FAST: src_code = CODE_FAST;
            SRC_SLOW: src_code = CODE_SLOW;
            SRC_EXT:  src_code = CODE_EXT;
            default:  src_code = '0;
        endcase
    endfunction

    function automatic logic [N_SRC-1:0] code_onehot(input logic [REG_W-1:0] code);
        logic [N_SRC-1:0] oh;
        oh = '0;
        for (int i = 0; i < N_SRC; i++) begin
            oh[i] = (code == src_code(i));
        end
        return oh;
    endfunction

endpackage

// File: rtl/clksw_code_check.sv
module clksw_code_check #(
    parameter int N        = clksw_pkg::N_SRC,
    parameter int W        = clksw_pkg::REG_W,
    parameter int LOCK_IDX = clksw_pkg::SRC_SLOW
) (
    input  logic [W-1:0] code,
    input  logic         lock,
    output logic [N-1:0] hit,
    output logic         allowed
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            assign hit[i] = (code == W'(clksw_pkg::src_code(i)));
        end
    endgenerate

    assign allowed = (|hit) && !(lock && hit[LOCK_IDX]);
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic go,
    input  logic tgt_ready,
    output logic busy,
    output logic commit,
    output logic done_set
);
    import clksw_pkg::*;

    sw_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        commit   = 1'b0;
        done_set = 1'b0;
        case (state_q)
            SW_IDLE: begin
                if (start) state_d = SW_WAIT;
            end
            SW_WAIT: begin
                if (abort) begin
                    state_d = SW_IDLE;
                end else if (tgt_ready) begin
                    done_set = 1'b1;
                    if (go) begin
                        commit  = 1'b1;
                        state_d = SW_IDLE;
                    end else begin
                        state_d = SW_HOLD;
                    end
                end
            end
            SW_HOLD: begin
                if (abort) begin
                    state_d = SW_IDLE;
                end else if (go) begin
                    commit  = 1'b1;
                    state_d = SW_IDLE;
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SW_IDLE;
        else     state_q <= state_d;
    end

    assign busy = (state_q != SW_IDLE);
endmodule

// File: rtl/clksw_osc_ctrl.sv
module clksw_osc_ctrl #(
    parameter int N         = clksw_pkg::N_SRC,
    parameter int RESET_IDX = clksw_pkg::SRC_FAST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_wr,
    input  logic [N-1:0] sw_data,
    input  logic         hw_set,
    input  logic [N-1:0] hw_mask,
    output logic [N-1:0] osc_en
);
    localparam logic [N-1:0] EN_RESET = N'(1) << RESET_IDX;

    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= EN_RESET;
        end else if (sw_wr) begin
            en_q <= sw_data;
        end else if (hw_set) begin
            en_q <= en_q | hw_mask;
        end
    end

    assign osc_en = en_q;
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [2:0] osc_ready,
    input  logic       slow_master_lock,
    output logic [2:0] osc_enable,
    output logic [2:0] master_sel,
    output logic       switch_irq
);
    import clksw_pkg::*;

    logic [REG_W-1:0] tgt_q;
    logic [REG_W-1:0] status_q;
    ctrl_t            ctrl_q;
    logic             done_flag;

    logic [N_SRC-1:0] wr_hit, tgt_hit;
    logic             wr_ok, tgt_ok;
    logic             wr_tgt, wr_ctrl, wr_osc;
    logic             start, abort, busy, commit, done_set, tgt_ready;

    assign wr_tgt  = bus_wr && (bus_addr == RA_TARGET);
    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_osc  = bus_wr && (bus_addr == RA_OSCEN);

    clksw_code_check u_wdec (
        .code    (bus_wdata),
        .lock    (slow_master_lock),
        .hit     (wr_hit),
        .allowed (wr_ok)
    );

    clksw_code_check u_tdec (
        .code    (tgt_q),
        .lock    (1'b0),
        .hit     (tgt_hit),
        .allowed (tgt_ok)
    );

    assign start     = wr_tgt && wr_ok && !busy;
    assign abort     = wr_ctrl && busy && !bus_wdata[CB_BUSY];
    assign tgt_ready = tgt_ok && |(tgt_hit & osc_ready);

    clksw_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .abort     (abort),
        .go        (ctrl_q.go),
        .tgt_ready (tgt_ready),
        .busy      (busy),
        .commit    (commit),
        .done_set  (done_set)
    );

    clksw_osc_ctrl u_osc (
        .clk     (clk),
        .rst     (rst),
        .sw_wr   (wr_osc),
        .sw_data (bus_wdata[N_SRC-1:0]),
        .hw_set  (start),
        .hw_mask (wr_hit),
        .osc_en  (osc_enable)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q    <= CODE_FAST;
            status_q <= CODE_FAST;
        end else begin
            if (start)      tgt_q <= bus_wdata;
            else if (abort) tgt_q <= status_q;
            if (commit)     status_q <= tgt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.go <= bus_wdata[CB_GO];
                ctrl_q.ie <= bus_wdata[CB_IE];
                if (!bus_wdata[CB_DONE]) ctrl_q.done <= 1'b0;
            end
            if (done_set) ctrl_q.done <= 1'b1;
        end
    end

    assign done_flag = ctrl_q.done;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_TARGET: bus_rdata = tgt_q;
            RA_STATUS: bus_rdata = status_q;
            RA_CTRL: begin
                bus_rdata[CB_BUSY] = busy;
                bus_rdata[CB_GO]   = ctrl_q.go;
                bus_rdata[CB_IE]   = ctrl_q.ie;
                bus_rdata[CB_DONE] = ctrl_q.done;
            end
            default: bus_rdata[N_SRC-1:0] = osc_enable;
        endcase
    end

    assign master_sel = code_onehot(status_q);
    assign switch_irq = ctrl_q.done && ctrl_q.ie;
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       slow_master_lock,
    input logic [2:0] osc_enable,
    input logic [2:0] master_sel,
    input logic       busy,
    input logic       done_flag,
    input logic [7:0] status,
    input logic [7:0] tgt
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(master_sel) == 1); // R5

    AST_SEL_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(master_sel)); // R4

    AST_STATUS_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(status) |-> ($past(busy) && !busy)); // R5

    AST_DONE_IN_SWITCH: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $past(busy)); // R6

    AST_EN_SW_ONLY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (|(~osc_enable & $past(osc_enable))) |-> $past(bus_wr && bus_addr == 2'd3)); // R9

    AST_LOCK_NO_SLOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(slow_master_lock)) |-> (tgt != 8'hD2)); // R11
endmodule

bind clk_source_switch clksw_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_wr           (bus_wr),
    .bus_addr         (bus_addr),
    .slow_master_lock (slow_master_lock),
    .osc_enable       (osc_enable),
    .master_sel       (master_sel),
    .busy             (busy),
    .done_flag        (done_flag),
    .status           (status_q),
    .tgt              (tgt_q)
);

// File: tb/clk_source_switch_bench.sv
`timescale 1ns/1ps
module clk_source_switch_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [2:0] osc_ready;
    logic       slow_master_lock = 1'b0;
    logic [2:0] osc_enable;
    logic [2:0] master_sel;
    logic       switch_irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    localparam int K_RD = 0, K_IRQ = 1, K_SEL = 2, K_EN = 3;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sbq[$];

    always #2 clk = ~clk;

    clk_source_switch u_clk_source_switch (
        .clk              (clk),
        .rst              (rst),
        .bus_wr           (bus_wr),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .osc_ready        (osc_ready),
        .slow_master_lock (slow_master_lock),
        .osc_enable       (osc_enable),
        .master_sel       (master_sel),
        .switch_irq       (switch_irq)
    );

    // oscillator model: ready after a per-source number of enabled cycles
    int unsigned dly [3] = '{4, 20, 10};
    int unsigned cnt [3];
    always_ff @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (rst || !osc_enable[i]) begin
                cnt[i]       <= 0;
                osc_ready[i] <= 1'b0;
            end else if (cnt[i] >= dly[i]) begin
                osc_ready[i] <= 1'b1;
            end else begin
                cnt[i] <= cnt[i] + 1;
            end
        end
    end

    // monitor: pop one expected item per falling edge and compare
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_IRQ:   act = {7'b0, switch_irq};
                    K_SEL:   act = {5'b0, master_sel};
                    default: act = {5'b0, osc_enable};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [1:0] a,
                               input logic [7:0] e, input string req);
        sb_item_t it;
        bus_addr = a;
        it.kind = kind; it.exp = e; it.req = req;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_not_busy();
        bus_addr = 2'd2;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!bus_rdata[0]) break;
        end
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_item(K_RD, 2'd1, 8'hE1, "R1 status");
        expect_item(K_RD, 2'd0, 8'hE1, "R1 target");
        expect_item(K_RD, 2'd2, 8'h00, "R1 control");
        expect_item(K_EN, 2'd0, 8'h01, "R1 enables");
        expect_item(K_SEL, 2'd0, 8'h01, "R1 select");
        expect_item(K_IRQ, 2'd0, 8'h00, "R1 irq");

        // R2 illegal code ignored
        wr(2'd0, 8'h55);
        expect_item(K_RD, 2'd0, 8'hE1, "R2 target kept");
        expect_item(K_RD, 2'd2, 8'h00, "R2 busy clear");
        expect_item(K_EN, 2'd0, 8'h01, "R2 enables kept");

        // automatic switch to external
        wr(2'd2, 8'h06);
        wr(2'd0, 8'hB4);
        expect_item(K_RD, 2'd2, 8'h07, "R3 busy set");
        expect_item(K_EN, 2'd0, 8'h05, "R3 external enabled");
        expect_item(K_SEL, 2'd0, 8'h01, "R4 select held");
        wr(2'd0, 8'hD2);
        expect_item(K_RD, 2'd0, 8'hB4, "R4 target write ignored");
        expect_item(K_RD, 2'd1, 8'hE1, "R4 status held");
        wait_not_busy();
        expect_item(K_RD, 2'd1, 8'hB4, "R5 status updated");
        expect_item(K_SEL, 2'd0, 8'h04, "R5 select external");
        expect_item(K_RD, 2'd2, 8'h0E, "R5 done set busy clear");
        expect_item(K_IRQ, 2'd0, 8'h01, "R7 irq high");
        expect_item(K_EN, 2'd0, 8'h05, "R9 old source still on");
        wr(2'd2, 8'h0E);
        expect_item(K_IRQ, 2'd0, 8'h01, "R8 write one keeps flag");
        wr(2'd2, 8'h06);
        expect_item(K_RD, 2'd2, 8'h06, "R8 flag cleared");
        expect_item(K_IRQ, 2'd0, 8'h00, "R7 irq low");

        // manual switch back to fast internal
        wr(2'd2, 8'h04);
        wr(2'd0, 8'hE1);
        idle(3);
        expect_item(K_RD, 2'd2, 8'h0D, "R6 flag set busy held");
        expect_item(K_RD, 2'd1, 8'hB4, "R6 status held");
        expect_item(K_SEL, 2'd0, 8'h04, "R6 select held");
        expect_item(K_IRQ, 2'd0, 8'h01, "R7 irq manual");
        wr(2'd2, 8'h0F);
        idle(1);
        expect_item(K_RD, 2'd1, 8'hE1, "R6 committed");
        expect_item(K_SEL, 2'd0, 8'h01, "R6 select fast");
        expect_item(K_RD, 2'd2, 8'h0E, "R6 control after commit");

        // abort a pending switch to slow internal
        wr(2'd2, 8'h04);
        wr(2'd0, 8'hD2);
        expect_item(K_RD, 2'd0, 8'hD2, "R3 target loaded");
        expect_item(K_EN, 2'd0, 8'h07, "R3 slow enabled");
        wr(2'd2, 8'h04);
        expect_item(K_RD, 2'd0, 8'hE1, "R10 target rolled back");
        expect_item(K_RD, 2'd2, 8'h04, "R10 busy cleared");
        idle(30);
        expect_item(K_RD, 2'd2, 8'h04, "R10 no flag after abort");
        expect_item(K_RD, 2'd1, 8'hE1, "R10 status kept");
        expect_item(K_SEL, 2'd0, 8'h01, "R10 select kept");
        expect_item(K_EN, 2'd0, 8'h07, "R9 enable not cleared by abort");

        // lock refuses slow internal
        slow_master_lock = 1'b1;
        wr(2'd0, 8'hD2);
        expect_item(K_RD, 2'd2, 8'h04, "R11 busy stays clear");
        expect_item(K_RD, 2'd0, 8'hE1, "R11 target kept");
        slow_master_lock = 1'b0;

        // automatic switch with interrupt disabled
        wr(2'd2, 8'h02);
        wr(2'd0, 8'hD2);
        idle(3);
        expect_item(K_RD, 2'd2, 8'h0A, "R5 done with ie clear");
        expect_item(K_IRQ, 2'd0, 8'h00, "R7 irq gated");
        expect_item(K_RD, 2'd1, 8'hD2, "R5 status slow");
        expect_item(K_SEL, 2'd0, 8'h02, "R5 select slow");

        // software turns off old sources
        wr(2'd3, 8'h02);
        expect_item(K_EN, 2'd0, 8'h02, "R9 software disable");
        expect_item(K_RD, 2'd3, 8'h02, "R9 enable readback");

        idle(2);
        if (!done_run) begin
            done_run = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            done_run = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule